// File: doc/BRIEF.md
# Low-Side Constant-Off-Time Current Regulator

This block is the digital core of the current regulation and hard-short protection for the low-side switches of a motor H-bridge. It receives a sampled load-current code and a junction-temperature code, together with a one-microsecond tick and a strobe that marks each output activation. When the load current reaches the regulation threshold, the block asks the bridge to go to high impedance for a fixed number of ticks. After that interval the outputs follow their inputs again.

Each activation strobe opens a blanking window. Inside that window the regulation comparison is suppressed and only the short-circuit comparison is made. A short found there latches the bridge off. The regulation threshold is held constant up to a fold temperature. Above it, the threshold falls linearly to a floor value. Beyond a trip temperature, an over-temperature latch holds the bridge off. Both fault latches are cleared only by a single-cycle clear strobe from the control logic. The over-temperature latch accepts that clear only after the die has cooled by the hysteresis amount.

Top module: `bridge_limit_ctrl`

## Requirements
- R1: During and after reset, tri_req, short_flag and otemp_flag are 0.
- R2: Outside the blanking window, with no off interval running, a cur_code (unsigned, LSB = 0.1 A) at or above the current threshold raises tri_req in the next cycle. tri_req then stays high through OFF_TICKS (default 20) us_tick cycles and falls in the cycle after the last of them. A current one code below the threshold does not raise it.
- R3: The blanking window starts in the cycle of act_pulse and lasts BLANK_TICKS (default 16) us_tick cycles after it. In that window, a current at or above the threshold but not above SHORT_THR raises neither tri_req nor short_flag. The first cycle after the window closes may trip regulation.
- R4: Inside the blanking window (the act_pulse cycle included), a cur_code above SHORT_THR (default 80, that is 8.0 A) sets short_flag and tri_req from the next cycle. A cur_code equal to SHORT_THR does not set short_flag.
- R5: temp_code is unsigned with an LSB of 1 °C. Up to T_FOLD (160) the threshold is LIM_NOM (65). At or above T_FLOOR (175) it is LIM_HOT (40). Between the two it is LIM_NOM - floor((temp - T_FOLD) * (LIM_NOM - LIM_HOT) / (T_FLOOR - T_FOLD)).
- R6: A temp_code above OT_TRIP (175) sets otemp_flag and tri_req from the next cycle. A temp_code equal to OT_TRIP does not set it.
- R7: clr_pulse clears otemp_flag only when temp_code is at or below OT_TRIP - OT_HYST (160) and the trip condition is absent.
- R8: clr_pulse clears short_flag in the next cycle. When a short is seen in the same cycle as clr_pulse, short_flag stays set.
- R9: An act_pulse while the off interval runs restarts the interval at a full OFF_TICKS.
- R10: While a fault latch is set, tri_req stays high regardless of act_pulse, cur_code and us_tick.
- R11: Outside the blanking window, a current above SHORT_THR only starts regulation: tri_req rises and short_flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| act_pulse | input | 1 | One-cycle strobe at each output activation |
| clr_pulse | input | 1 | One-cycle strobe that clears the fault latches |
| cur_code | input | CUR_W | Low-side load current, 0.1 A per LSB |
| temp_code | input | TEMP_W | Junction temperature, 1 °C per LSB |
| tri_req | output | 1 | Request to put the whole bridge in high impedance |
| short_flag | output | 1 | Hard-short latch |
| otemp_flag | output | 1 | Over-temperature latch |

## Verification
Two events can fall in one cycle: an activation strobe, and a current crossing, either of the regulation threshold or of the short threshold. The decision for that cycle must come from the blanking rule, not from the window counter that the strobe has not loaded yet. The bench drives act_pulse in the same cycle as a current of 8.0 A and then of 8.1 A. It expects no reaction in the first case and a latched short in the second. It also times a threshold-level current against the last tick of the window, so that the regulation trip must land exactly one cycle after the window closes. A clear strobe that coincides with a short, and a clear that coincides with a temperature still above the hysteresis bound, are judged by whether the latch survives.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef struct packed {
    logic short_f;
    logic otemp_f;
  } blc_fault_t;
endpackage

// File: rtl/blc_rst_sync.sv
module blc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/blc_fold.sv
module blc_fold #(
  parameter int CUR_W   = 8,
  parameter int TEMP_W  = 8,
  parameter int LIM_NOM = 65,
  parameter int LIM_HOT = 40,
  parameter int T_FOLD  = 160,
  parameter int T_FLOOR = 175
) (
  input  logic [TEMP_W-1:0] temp_code,
  output logic [CUR_W-1:0]  limit
);
  localparam int SPAN = T_FLOOR - T_FOLD;
  localparam int DROP = LIM_NOM - LIM_HOT;
  localparam int PW   = TEMP_W + CUR_W + 1;

  generate
    if (SPAN > 0) begin : g_ramp
      logic [PW-1:0] excess;
      logic [PW-1:0] scaled;
      always_comb begin
        excess = PW'(temp_code) - PW'(T_FOLD);
        scaled = (excess * PW'(DROP)) / PW'(SPAN);
        if (temp_code <= TEMP_W'(T_FOLD))       limit = CUR_W'(LIM_NOM);
        else if (temp_code >= TEMP_W'(T_FLOOR)) limit = CUR_W'(LIM_HOT);
        else                                    limit = CUR_W'(PW'(LIM_NOM) - scaled);
      end
    end else begin : g_step
      always_comb begin
        if (temp_code <= TEMP_W'(T_FOLD)) limit = CUR_W'(LIM_NOM);
        else                              limit = CUR_W'(LIM_HOT);
      end
    end
  endgenerate
endmodule

// File: rtl/blc_window.sv
module blc_window #(
  parameter int TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign active = (cnt_q != '0);
  assign cnt_en = load | (tick & active);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = CW'(TICKS);
    else if (tick && active) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/blc_latch.sv
module blc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d, q_en;

  assign q_en = set | clr;

  always_comb begin
    q_d = q;
    if (set)      q_d = 1'b1;
    else if (clr) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/bridge_limit_ctrl.sv
module bridge_limit_ctrl #(
  parameter int CUR_W       = 8,
  parameter int TEMP_W      = 8,
  parameter int OFF_TICKS   = 20,
  parameter int BLANK_TICKS = 16,
  parameter int LIM_NOM     = 65,
  parameter int LIM_HOT     = 40,
  parameter int SHORT_THR   = 80,
  parameter int T_FOLD      = 160,
  parameter int T_FLOOR     = 175,
  parameter int OT_TRIP     = 175,
  parameter int OT_HYST     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              act_pulse,
  input  logic              clr_pulse,
  input  logic [CUR_W-1:0]  cur_code,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              tri_req,
  output logic              short_flag,
  output logic              otemp_flag
);
  import blc_pkg::*;

  localparam int OT_RELEASE = OT_TRIP - OT_HYST;

  logic             rst_ok_n;
  logic [CUR_W-1:0] limit;
  logic             blank_act, blank_open;
  logic             off_act, off_load, lim_trip;
  blc_fault_t       fset, fclr, fstate;

  blc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ok_n));

  blc_fold #(
    .CUR_W(CUR_W), .TEMP_W(TEMP_W), .LIM_NOM(LIM_NOM), .LIM_HOT(LIM_HOT),
    .T_FOLD(T_FOLD), .T_FLOOR(T_FLOOR)
  ) u_fold (.temp_code(temp_code), .limit(limit));

  blc_window #(.TICKS(BLANK_TICKS)) u_blank (
    .clk(clk), .rst_n(rst_ok_n), .tick(us_tick), .load(act_pulse), .active(blank_act)
  );

  blc_window #(.TICKS(OFF_TICKS)) u_off (
    .clk(clk), .rst_n(rst_ok_n), .tick(us_tick), .load(off_load), .active(off_act)
  );

  always_comb begin
    blank_open   = act_pulse | blank_act;
    lim_trip     = ~blank_open & ~off_act & (cur_code >= limit);
    off_load     = lim_trip | (act_pulse & off_act);
    fset.short_f = blank_open & (cur_code > CUR_W'(SHORT_THR));
    fset.otemp_f = (temp_code > TEMP_W'(OT_TRIP));
    fclr.short_f = clr_pulse;
    fclr.otemp_f = clr_pulse & (temp_code <= TEMP_W'(OT_RELEASE));
  end

  blc_latch u_short (
    .clk(clk), .rst_n(rst_ok_n), .set(fset.short_f), .clr(fclr.short_f), .q(fstate.short_f)
  );

  blc_latch u_otemp (
    .clk(clk), .rst_n(rst_ok_n), .set(fset.otemp_f), .clr(fclr.otemp_f), .q(fstate.otemp_f)
  );

  assign short_flag = fstate.short_f;
  assign otemp_flag = fstate.otemp_f;
  assign tri_req    = off_act | fstate.short_f | fstate.otemp_f;
endmodule

// File: rtl/blc_checker.sv
module blc_checker #(
  parameter int CUR_W     = 8,
  parameter int TEMP_W    = 8,
  parameter int SHORT_THR = 80,
  parameter int OT_TRIP   = 175,
  parameter int OT_HYST   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              us_tick,
  input logic              act_pulse,
  input logic              clr_pulse,
  input logic [CUR_W-1:0]  cur_code,
  input logic [TEMP_W-1:0] temp_code,
  input logic              tri_req,
  input logic              short_flag,
  input logic              otemp_flag
);
  AST_SHORT_IN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse && (cur_code > CUR_W'(SHORT_THR)) |=> short_flag && tri_req); // R4

  AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    short_flag && !clr_pulse |=> short_flag); // R8

  AST_OT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    temp_code > TEMP_W'(OT_TRIP) |=> otemp_flag && tri_req); // R6

  AST_OT_HYST: assert property (@(posedge clk) disable iff (!rst_n)
    otemp_flag && !(clr_pulse && (temp_code <= TEMP_W'(OT_TRIP - OT_HYST))) |=> otemp_flag); // R7

  AST_OFF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req && !us_tick && !clr_pulse |=> tri_req); // R2

  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse && !tri_req && (cur_code <= CUR_W'(SHORT_THR)) &&
    (temp_code <= TEMP_W'(OT_TRIP)) |=> !tri_req); // R3
endmodule

bind bridge_limit_ctrl blc_checker #(
  .CUR_W(CUR_W), .TEMP_W(TEMP_W), .SHORT_THR(SHORT_THR), .OT_TRIP(OT_TRIP), .OT_HYST(OT_HYST)
) chk_i (
  .clk(clk), .rst_n(rst_ok_n), .us_tick(us_tick), .act_pulse(act_pulse),
  .clr_pulse(clr_pulse), .cur_code(cur_code), .temp_code(temp_code),
  .tri_req(tri_req), .short_flag(short_flag), .otemp_flag(otemp_flag)
);

// File: tb/bridge_limit_ctrl_tb_top.sv
`timescale 1ns/1ps
module bridge_limit_ctrl_tb_top;
  localparam int OFF_T   = 20;
  localparam int BLANK_T = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       us_tick, act_pulse, clr_pulse;
  logic [7:0] cur_code, temp_code;
  logic       tri_req, short_flag, otemp_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bridge_limit_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .act_pulse(act_pulse),
    .clr_pulse(clr_pulse), .cur_code(cur_code), .temp_code(temp_code),
    .tri_req(tri_req), .short_flag(short_flag), .otemp_flag(otemp_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick_once();
    us_tick = 1'b1;
    step();
    us_tick = 1'b0;
  endtask

  task automatic drain();
    cur_code = 8'd0;
    for (int i = 0; i < OFF_T + 2; i++) begin
      tick_once();
      step();
    end
  endtask

  // Expected regulation threshold, 0.1 A per LSB
  function automatic int exp_limit(input int t);
    if (t <= 160) return 65;
    if (t >= 175) return 40;
    return 65 - ((t - 160) * 25) / 15;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; us_tick = 0; act_pulse = 0; clr_pulse = 0;
    cur_code = 0; temp_code = 8'd25;
    step(); step();
    check("R1 tri_req in reset", tri_req, 1'b0);
    check("R1 short_flag in reset", short_flag, 1'b0);
    check("R1 otemp_flag in reset", otemp_flag, 1'b0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 tri_req after reset", tri_req, 1'b0);
  endtask

  task automatic t_limit_timing();
    temp_code = 8'd25;
    cur_code = 8'd64; step();
    check("R2 below threshold", tri_req, 1'b0);
    cur_code = 8'd65; step();
    check("R2 trip at threshold", tri_req, 1'b1);
    cur_code = 8'd0;
    for (int i = 1; i < OFF_T; i++) begin
      tick_once();
      step();
    end
    check("R2 held through last-but-one tick", tri_req, 1'b1);
    tick_once();
    check("R2 released after last tick", tri_req, 1'b0);
    drain();
  endtask

  task automatic t_fold(input int t);
    int lim;
    lim = exp_limit(t);
    temp_code = 8'(t);
    cur_code = 8'(lim - 1); step();
    check($sformatf("R5 t=%0d below %0d", t, lim), tri_req, 1'b0);
    cur_code = 8'(lim); step();
    check($sformatf("R5 t=%0d at %0d", t, lim), tri_req, 1'b1);
    check("R6 no trip at or below trip temperature", otemp_flag, 1'b0);
    drain();
    temp_code = 8'd25;
  endtask

  task automatic t_blanking();
    cur_code = 8'd70;
    act_pulse = 1'b1; step(); act_pulse = 1'b0;
    check("R3 act cycle ignores limit", tri_req, 1'b0);
    for (int i = 1; i < BLANK_T; i++) begin
      tick_once();
      step();
    end
    check("R3 quiet inside window", tri_req, 1'b0);
    tick_once();
    check("R3 quiet on final window tick", tri_req, 1'b0);
    check("R3 no short for limit-level current", short_flag, 1'b0);
    step();
    check("R3 trip right after window", tri_req, 1'b1);
    drain();
  endtask

  task automatic t_restart();
    cur_code = 8'd65; step(); cur_code = 8'd0;
    check("R9 off interval started", tri_req, 1'b1);
    for (int i = 0; i < 10; i++) tick_once();
    act_pulse = 1'b1; step(); act_pulse = 1'b0;
    for (int i = 0; i < 10; i++) tick_once();
    check("R9 interval restarted by activation", tri_req, 1'b1);
    for (int i = 0; i < 9; i++) tick_once();
    check("R9 still off one tick before new end", tri_req, 1'b1);
    tick_once();
    check("R9 released after full reload", tri_req, 1'b0);
    drain();
  endtask

  task automatic t_no_blank_short();
    cur_code = 8'd120; step();
    check("R11 regulation trip", tri_req, 1'b1);
    check("R11 no short outside window", short_flag, 1'b0);
    drain();
  endtask

  task automatic t_short();
    act_pulse = 1'b1; cur_code = 8'd80; step(); act_pulse = 1'b0;
    check("R4 equal to short threshold", short_flag, 1'b0);
    check("R4 no tri at equal threshold", tri_req, 1'b0);
    cur_code = 8'd81; step();
    check("R4 short inside window", short_flag, 1'b1);
    check("R4 tri on short", tri_req, 1'b1);
    cur_code = 8'd0;
    for (int i = 0; i < 30; i++) begin
      act_pulse = i[0];
      tick_once();
      act_pulse = 1'b0;
    end
    check("R10 latch holds bridge off", tri_req, 1'b1);
    act_pulse = 1'b1; cur_code = 8'd90; clr_pulse = 1'b1; step();
    act_pulse = 1'b0; clr_pulse = 1'b0; cur_code = 8'd0;
    check("R8 set wins over clear", short_flag, 1'b1);
    clr_pulse = 1'b1; step(); clr_pulse = 1'b0;
    check("R8 cleared by strobe", short_flag, 1'b0);
    check("R8 tri released after clear", tri_req, 1'b0);
    drain();
  endtask

  task automatic t_overtemp();
    temp_code = 8'd176; step();
    check("R6 trip above limit", otemp_flag, 1'b1);
    check("R6 tri on overtemp", tri_req, 1'b1);
    clr_pulse = 1'b1; step(); clr_pulse = 1'b0;
    check("R7 clear ignored while hot", otemp_flag, 1'b1);
    temp_code = 8'd161;
    clr_pulse = 1'b1; step(); clr_pulse = 1'b0;
    check("R7 clear ignored inside hysteresis", otemp_flag, 1'b1);
    check("R10 tri held by overtemp", tri_req, 1'b1);
    temp_code = 8'd160;
    clr_pulse = 1'b1; step(); clr_pulse = 1'b0;
    check("R7 clear accepted when cool", otemp_flag, 1'b0);
    check("R7 tri released", tri_req, 1'b0);
    temp_code = 8'd25;
  endtask

  initial begin
    t_reset();
    t_limit_timing();
    t_fold(25);
    t_fold(161);
    t_fold(170);
    t_fold(175);
    t_blanking();
    t_restart();
    t_no_blank_short();
    t_short();
    t_overtemp();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule